// File: doc/BRIEF.md
# Synchronous burst SRAM cycle controller

This block sits in front of a small single-port storage array and turns the clocked control pins of a burst SRAM into one cycle decision per rising clock edge. It takes three chip enables, two address strobes of unequal priority (a processor strobe and a controller strobe), a burst-advance pin, a global write, a byte-write enable with one strobe per byte lane, a sleep pin and an asynchronous output enable. For each edge it reports the cycle type, the source the address came from and the byte lanes written. It also gives the enable that lets the read data drive the shared data bus.

The burst address sequence is not generated here. A separate counter supplies the address used on continue and suspend cycles (`burst_addr`), and reads `addr_src` to decide whether to load, step or hold. Read data follows the edge that registered the read (flow-through). Write data is captured on the same edge as the write controls.

Top module: `sbsram_cycle_ctrl`

## Requirements
- R1: With sleep low, chip enable 1 low, chip enable 2 high, chip enable 3 low and the processor strobe low, the edge registers a read from the external address (`cyc_type`=2, `addr_src`=1), whatever the write controls and the controller strobe are doing.
- R2: With sleep low, the processor strobe high, the controller strobe low and the chip selected, the edge registers a burst start from the external address (`addr_src`=1). It is a write (`cyc_type`=3) when the merged write request is active and a read (`cyc_type`=2) otherwise.
- R3: The merged write request is active when global write is low, or when byte-write enable is low with at least one byte strobe low. `lane_we` bit i covers data bits 8i+7..8i and follows `bw_n[i]` low when byte-write enable is low. Global write low sets every bit. `lane_we` is nonzero only on a write cycle.
- R4: Chip enable 1 high with the controller strobe low gives a deselect (`cyc_type`=0, `addr_src`=0), whatever the processor strobe does. With chip enable 1 low, either strobe low while chip enable 2 is low or chip enable 3 is high also gives a deselect.
- R5: When neither strobe starts a cycle (both high, or chip enable 1 high with the controller strobe high), advance low gives `addr_src`=2 (next) and advance high gives `addr_src`=3 (current). The storage is accessed at `burst_addr`, and the merged write request picks read or write.
- R6: Sleep high gives `cyc_type`=1 and `addr_src`=0. The storage is not written, and `data_oe` is low while sleep is high.
- R7: `data_oe` is high only when the registered cycle is a read, output enable is low and sleep is low. It follows output enable without waiting for a clock edge, and it stays low during write cycles.
- R8: The edge on which the processor strobe starts a burst never writes the storage, even with global write or byte writes asserted.
- R9: While reset is asserted, `cyc_type`=0, `addr_src`=0, `lane_we`=0 and `data_oe`=0.
- R10: A write changes only the lanes named in `lane_we`. After the edge that registers a read, `rdata` shows the addressed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| zz | input | 1 | Sleep request, active high |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Byte strobes, active low, bit i for lane i |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| ext_addr | input | AW | External address for burst starts |
| burst_addr | input | AW | Address from the burst counter |
| wdata | input | LANES*8 | Write data |
| cyc_type | output | 2 | 0 deselect, 1 sleep, 2 read, 3 write |
| addr_src | output | 2 | 0 none, 1 external, 2 next, 3 current |
| lane_we | output | LANES | Lanes written on the last edge |
| rdata | output | LANES*8 | Read data, flow-through |
| data_oe | output | 1 | Data bus drive enable |

## Verification
The properties assume every control input is a clean 0 or 1 that does not change at the rising edge. They also assume `burst_addr` is a valid index whenever a continue or suspend cycle can occur. The bench drives all inputs on the falling edge and samples the registered outputs on the next falling edge. It changes `oe_n` and `zz` between edges only to observe the asynchronous path of `data_oe`.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
   typedef enum logic [1:0] {
      CYC_DESEL = 2'd0,
      CYC_SLEEP = 2'd1,
      CYC_READ  = 2'd2,
      CYC_WRITE = 2'd3
   } cyc_e;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_EXT  = 2'd1,
      SRC_NEXT = 2'd2,
      SRC_CUR  = 2'd3
   } src_e;

   localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/sbc_write_merge.sv
module sbc_write_merge #(
   parameter int unsigned LANES = 4
) (
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] bw_n,
   output logic             wr_req,
   output logic [LANES-1:0] lane_mask
);
   always_comb begin
      if (!gw_n)
         lane_mask = '1;
      else if (!bwe_n)
         lane_mask = ~bw_n;
      else
         lane_mask = '0;
   end

   assign wr_req = |lane_mask;
endmodule

// File: rtl/sbc_cycle_decode.sv
module sbc_cycle_decode
   import sbc_pkg::*;
(
   input  logic zz,
   input  logic ce1_n,
   input  logic ce2,
   input  logic ce3_n,
   input  logic adsp_n,
   input  logic adsc_n,
   input  logic adv_n,
   input  logic wr_req,
   output cyc_e cyc,
   output src_e src
);
   logic sel_full;
   logic start_p;
   logic start_c;

   assign sel_full = !ce1_n && ce2 && !ce3_n;
   assign start_p  = !adsp_n && !ce1_n;
   assign start_c  = !adsc_n;

   always_comb begin
      cyc = CYC_DESEL;
      src = SRC_NONE;
      if (zz) begin
         cyc = CYC_SLEEP;
      end else if (ce1_n && start_c) begin
         cyc = CYC_DESEL;
      end else if (start_p || start_c) begin
         if (!sel_full) begin
            cyc = CYC_DESEL;
         end else begin
            src = SRC_EXT;
            if (start_p)
               cyc = CYC_READ;
            else
               cyc = wr_req ? CYC_WRITE : CYC_READ;
         end
      end else begin
         src = adv_n ? SRC_CUR : SRC_NEXT;
         cyc = wr_req ? CYC_WRITE : CYC_READ;
      end
   end
endmodule

// File: rtl/sbc_lane_store.sv
module sbc_lane_store #(
   parameter int unsigned AW    = 4,
   parameter int unsigned LANES = 4,
   parameter int unsigned LW    = 8
) (
   input  logic                clk,
   input  logic [LANES-1:0]    we,
   input  logic [AW-1:0]       waddr,
   input  logic [LANES*LW-1:0] wdata,
   input  logic [AW-1:0]       raddr,
   output logic [LANES*LW-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << AW;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LW-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (we[g])
            cells[waddr] <= wdata[g*LW +: LW];
      end

      assign rdata[g*LW +: LW] = cells[raddr];
   end
endmodule

// File: rtl/sbsram_cycle_ctrl.sv
module sbsram_cycle_ctrl
   import sbc_pkg::*;
#(
   parameter int unsigned AW    = 4,
   parameter int unsigned LANES = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    zz,
   input  logic                    ce1_n,
   input  logic                    ce2,
   input  logic                    ce3_n,
   input  logic                    adsp_n,
   input  logic                    adsc_n,
   input  logic                    adv_n,
   input  logic                    gw_n,
   input  logic                    bwe_n,
   input  logic [LANES-1:0]        bw_n,
   input  logic                    oe_n,
   input  logic [AW-1:0]           ext_addr,
   input  logic [AW-1:0]           burst_addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [1:0]              cyc_type,
   output logic [1:0]              addr_src,
   output logic [LANES-1:0]        lane_we,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    data_oe
);
   localparam int unsigned DW = LANES * LANE_W;

   if (LANES < 1 || LANES > 16) begin : g_bad_lanes
      $error("sbsram_cycle_ctrl: LANES must lie in 1..16");
   end
   if (AW < 1 || AW > 10) begin : g_bad_aw
      $error("sbsram_cycle_ctrl: AW must lie in 1..10");
   end

   logic             wr_req;
   logic [LANES-1:0] lane_mask;
   cyc_e             cyc_d;
   src_e             src_d;
   cyc_e             cyc_q;
   src_e             src_q;
   logic [LANES-1:0] commit_we;
   logic [AW-1:0]    acc_addr;
   logic [AW-1:0]    rd_addr_q;
   logic [DW-1:0]    store_rdata;

   sbc_write_merge #(.LANES(LANES)) u_merge (
      .gw_n      (gw_n),
      .bwe_n     (bwe_n),
      .bw_n      (bw_n),
      .wr_req    (wr_req),
      .lane_mask (lane_mask)
   );

   sbc_cycle_decode u_decode (
      .zz     (zz),
      .ce1_n  (ce1_n),
      .ce2    (ce2),
      .ce3_n  (ce3_n),
      .adsp_n (adsp_n),
      .adsc_n (adsc_n),
      .adv_n  (adv_n),
      .wr_req (wr_req),
      .cyc    (cyc_d),
      .src    (src_d)
   );

   assign acc_addr  = (src_d == SRC_EXT) ? ext_addr : burst_addr;
   assign commit_we = (cyc_d == CYC_WRITE) ? lane_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q     <= CYC_DESEL;
         src_q     <= SRC_NONE;
         lane_we   <= '0;
         rd_addr_q <= '0;
      end else begin
         cyc_q   <= cyc_d;
         src_q   <= src_d;
         lane_we <= commit_we;
         if (cyc_d == CYC_READ || cyc_d == CYC_WRITE)
            rd_addr_q <= acc_addr;
      end
   end

   sbc_lane_store #(.AW(AW), .LANES(LANES), .LW(LANE_W)) u_store (
      .clk   (clk),
      .we    (commit_we),
      .waddr (acc_addr),
      .wdata (wdata),
      .raddr (rd_addr_q),
      .rdata (store_rdata)
   );

   assign rdata    = store_rdata;
   assign cyc_type = cyc_q;
   assign addr_src = src_q;
   assign data_oe  = (cyc_q == CYC_READ) && !oe_n && !zz;
endmodule

// File: rtl/sbc_cycle_ctrl_chk.sv
module sbc_cycle_ctrl_chk #(
   parameter int unsigned LANES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             zz,
   input logic             ce1_n,
   input logic             ce2,
   input logic             ce3_n,
   input logic             adsp_n,
   input logic             adsc_n,
   input logic             adv_n,
   input logic             gw_n,
   input logic             oe_n,
   input logic [1:0]       cyc_type,
   input logic [1:0]       addr_src,
   input logic [LANES-1:0] lane_we,
   input logic             data_oe
);
   // R1: processor strobe with full select starts an external read
   a_r1_adsp_read: assert property (@(posedge clk) disable iff (!rst_n)
      (!zz && !ce1_n && ce2 && !ce3_n && !adsp_n) |=> (cyc_type == 2'd2 && addr_src == 2'd1));

   // R8: processor strobe edge never writes
   a_r8_adsp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!zz && !ce1_n && !adsp_n) |=> (lane_we == '0));

   // R4: chip enable 1 high with controller strobe deselects
   a_r4_ce1_desel: assert property (@(posedge clk) disable iff (!rst_n)
      (!zz && ce1_n && !adsc_n) |=> (cyc_type == 2'd0 && addr_src == 2'd0));

   // R6: sleep wins and writes nothing
   a_r6_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      zz |=> (cyc_type == 2'd1 && lane_we == '0));

   // R3: global write on a continue/suspend cycle writes all lanes
   a_r3_gw_all: assert property (@(posedge clk) disable iff (!rst_n)
      (!zz && !gw_n && adsc_n && (adsp_n || ce1_n)) |=> (lane_we == '1));

   // R3: lane strobes appear only on write cycles
   a_r3_we_only_write: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_we != '0) |-> (cyc_type == 2'd3));

   // R5: advance low without a start steps to the next address
   a_r5_next: assert property (@(posedge clk) disable iff (!rst_n)
      (!zz && adsc_n && (adsp_n || ce1_n) && !adv_n) |=> (addr_src == 2'd2));

   // R7: no bus drive during a write cycle
   a_r7_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_type == 2'd3) |-> !data_oe);

   // R7: no bus drive while output enable is high
   a_r7_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !data_oe);
endmodule

bind sbsram_cycle_ctrl sbc_cycle_ctrl_chk #(.LANES(LANES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .zz       (zz),
   .ce1_n    (ce1_n),
   .ce2      (ce2),
   .ce3_n    (ce3_n),
   .adsp_n   (adsp_n),
   .adsc_n   (adsc_n),
   .adv_n    (adv_n),
   .gw_n     (gw_n),
   .oe_n     (oe_n),
   .cyc_type (cyc_type),
   .addr_src (addr_src),
   .lane_we  (lane_we),
   .data_oe  (data_oe)
);

// File: tb/test_sbsram_cycle_ctrl.sv
`timescale 1ns/1ps
module test_sbsram_cycle_ctrl;
   localparam int unsigned AW    = 4;
   localparam int unsigned LANES = 4;
   localparam int unsigned DW    = LANES * 8;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             zz, ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n;
   logic [LANES-1:0] bw_n;
   logic [AW-1:0]    ext_addr, burst_addr;
   logic [DW-1:0]    wdata;
   logic [1:0]       cyc_type, addr_src;
   logic [LANES-1:0] lane_we;
   logic [DW-1:0]    rdata;
   logic             data_oe;

   int compared   = 0;
   int mismatched = 0;
   bit done       = 1'b0;

   always #10 clk = ~clk;

   sbsram_cycle_ctrl #(.AW(AW), .LANES(LANES)) i_sbsram_cycle_ctrl (
      .clk(clk), .rst_n(rst_n), .zz(zz), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
      .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
      .bw_n(bw_n), .oe_n(oe_n), .ext_addr(ext_addr), .burst_addr(burst_addr),
      .wdata(wdata), .cyc_type(cyc_type), .addr_src(addr_src), .lane_we(lane_we),
      .rdata(rdata), .data_oe(data_oe)
   );

   // {zz,ce1_n,ce2,ce3_n,adsp_n,adsc_n,adv_n,gw_n,bwe_n,bw_n[3:0]} , {cyc,src,lane_we}
   localparam int NV = 14;
   localparam logic [20:0] VEC [NV] = '{
      21'b1_0_1_0_0_0_0_0_0_0000_01_00_0000, // R6 sleep
      21'b0_0_1_0_0_1_1_0_0_0000_10_01_0000, // R1 adsp read, gw low
      21'b0_0_1_0_1_0_1_0_1_1111_11_01_1111, // R2 adsc global write
      21'b0_0_1_0_1_0_1_1_0_1010_11_01_0101, // R3 adsc byte write lanes 0,2
      21'b0_0_1_0_1_0_1_1_0_1111_10_01_0000, // R3 bwe low, no strobe -> read
      21'b0_0_1_0_1_0_1_1_1_0000_10_01_0000, // R3 strobes without bwe -> read
      21'b0_1_1_0_0_0_0_0_0_0000_00_00_0000, // R4 ce1 high, adsc low
      21'b0_0_0_0_0_1_0_1_1_1111_00_00_0000, // R4 ce2 low, adsp low
      21'b0_0_1_1_1_0_0_1_1_1111_00_00_0000, // R4 ce3 high, adsc low
      21'b0_0_1_0_1_1_0_1_1_1111_10_10_0000, // R5 continue read
      21'b0_0_1_0_1_1_1_1_0_0111_11_11_1000, // R5 suspend byte write lane 3
      21'b0_1_0_1_0_1_0_0_1_1111_11_10_1111, // R5 ce1 high hides adsp
      21'b0_0_0_1_1_1_1_1_1_1111_10_11_0000, // R5 suspend read, ce2/ce3 ignored
      21'b0_0_1_0_0_0_1_1_0_0000_10_01_0000  // R8 adsp beats adsc and byte writes
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle();
      zz = 1'b0; ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1;
      adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
      gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1;
   endtask

   task automatic select();
      ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      idle();
      oe_n = 1'b0; ext_addr = '0; burst_addr = '0; wdata = '0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 cyc_type", 32'(cyc_type), 32'd0);
      chk("R9 addr_src", 32'(addr_src), 32'd0);
      chk("R9 lane_we", 32'(lane_we), 32'd0);
      chk("R9 data_oe", 32'(data_oe), 32'd0);
      rst_n = 1'b1;
      oe_n = 1'b1;
      ext_addr = 4'd7; burst_addr = 4'd8; wdata = 32'h5A5A_5A5A;

      for (int i = 0; i < NV; i++) begin
         {zz, ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, bw_n} = VEC[i][20:8];
         tick();
         chk($sformatf("vec%0d cyc_type", i), 32'(cyc_type), 32'(VEC[i][7:6]));
         chk($sformatf("vec%0d addr_src", i), 32'(addr_src), 32'(VEC[i][5:4]));
         chk($sformatf("vec%0d lane_we", i), 32'(lane_we), 32'(VEC[i][3:0]));
      end

      // R2/R10 full-word write at address 3
      idle(); select(); adsc_n = 1'b0; gw_n = 1'b0;
      ext_addr = 4'd3; wdata = 32'h1122_3344; oe_n = 1'b1;
      tick();
      chk("R2 full write lanes", 32'(lane_we), 32'hF);

      // R10 byte write of lane 1 only
      gw_n = 1'b1; bwe_n = 1'b0; bw_n = 4'b1101; wdata = 32'hAABB_CCDD;
      tick();
      chk("R10 lane1 write strobe", 32'(lane_we), 32'h2);

      // R8/R1 processor strobe read with global write held low
      idle(); select(); adsp_n = 1'b0; gw_n = 1'b0; wdata = 32'h0; oe_n = 1'b0;
      tick();
      chk("R1 adsp cycle", 32'(cyc_type), 32'd2);
      chk("R8 R10 merged word", rdata, 32'h1122_CC44);
      chk("R7 drive on read", 32'(data_oe), 32'd1);
      oe_n = 1'b1; #1;
      chk("R7 async release", 32'(data_oe), 32'd0);
      oe_n = 1'b0;

      // R5 write at burst_addr via continue cycle
      idle(); adv_n = 1'b0; gw_n = 1'b0; burst_addr = 4'd5; wdata = 32'hCAFE_0005;
      tick();
      chk("R5 continue write src", 32'(addr_src), 32'd2);
      chk("R7 masked in write", 32'(data_oe), 32'd0);

      // R5 read back address 5 from the external side
      idle(); select(); adsc_n = 1'b0; ext_addr = 4'd5; burst_addr = 4'd9;
      tick();
      chk("R5 burst_addr used", rdata, 32'hCAFE_0005);

      // R6 sleep ignores a write request
      idle(); select(); zz = 1'b1; adsc_n = 1'b0; gw_n = 1'b0; wdata = 32'h0;
      tick();
      chk("R6 sleep cycle", 32'(cyc_type), 32'd1);
      chk("R6 no drive", 32'(data_oe), 32'd0);

      idle(); select(); adsc_n = 1'b0; ext_addr = 4'd5;
      tick();
      chk("R6 storage untouched", rdata, 32'hCAFE_0005);
      zz = 1'b1; #1;
      chk("R6 async float", 32'(data_oe), 32'd0);
      zz = 1'b0;

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual expired expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule